// File: doc/BRIEF.md
# Bus Parallel Poll Responder

This block answers IEEE-488 parallel polls for one bus interface device. It holds the device's parallel poll configuration (unconfigured, configured and waiting, or answering a poll) together with the number of the data line it answers on. While a poll is in progress, it raises that one line, but only if the local status bit matches the polarity chosen in the control register. The response is ORed onto the byte that the other interface functions are driving, so it never hides their data.

At power-on clear the block sets itself up without any command from the bus. A device whose address is at most seven is configured at once and answers on the line given by the address with all three low bits inverted. A device with a higher address stays unconfigured until a configuration load arrives. A simple load port stands in for remote enable and disable commands. It either sets a line number and configures the device, or it removes the configuration. When the local controller starts a poll, the block also combines the EOI request with any EOI that the other functions drive.

Top module: `ppr_responder`

## Requirements
- R1: A cycle with `pwr_on_clr` high and `dev_addr` at most 7 leaves the block configured (standby), with response line `dev_addr[2:0] ^ 3'b111`.
- R2: A cycle with `pwr_on_clr` high and `dev_addr` at 8 or above leaves the block unconfigured (idle). A poll then adds no bit to `dio_out`.
- R3: In standby, a clock edge with `atn` and `eoi` both high moves the block to active. In active, an edge with either one low moves it back to standby.
- R4: A response bit is driven only in the active state, and only while `ist_local` equals `sense_pol`. Otherwise `resp_mask` is 0.
- R5: The response is one-hot. `resp_mask` has only bit number `line` set, where bit 0 is DIO1.
- R6: `dio_out` equals `src_byte | resp_mask`. Bits already set in `src_byte` are never cleared.
- R7: `eoi_drive` equals `src_eoi | ctl_poll`, with no register on the path.
- R8: A cycle with `cfg_load` high and `cfg_enable` high loads `cfg_line` and moves idle to standby. Standby and active states are kept. A load with `cfg_enable` low moves the block to idle from any state. A load takes priority over `atn`/`eoi` in the same cycle.
- R9: `resp_mask` shows the response in the first cycle after the edge that enters active. There is no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_clr | input | 1 | Synchronous power-on clear. Active high. Runs the address-based setup. |
| dev_addr | input | 5 | Device bus address, sampled during power-on clear |
| atn | input | 1 | Bus ATN line, true-high |
| eoi | input | 1 | Bus EOI line, true-high |
| ist_local | input | 1 | Local status bit |
| sense_pol | input | 1 | Control-register polarity that `ist_local` must match |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_enable | input | 1 | 1 = configure with `cfg_line`, 0 = unconfigure |
| cfg_line | input | 3 | Response line number to load |
| src_byte | input | 8 | Data byte driven by the other interface functions |
| src_eoi | input | 1 | EOI requested by the other interface functions |
| ctl_poll | input | 1 | Local controller is running a parallel poll |
| resp_mask | output | 8 | One-hot poll response of this block |
| dio_out | output | 8 | Merged byte for the data lines |
| eoi_drive | output | 1 | Merged EOI request |

## Verification
A wrong configuration state shows at the ports only during a poll. There, a missing bit, an extra bit or a bit on the wrong line appears in `dio_out` one clock after ATN and EOI are both seen high. For this reason every power-on and load scenario ends with a poll. A state that fails to leave active shows up as a stale bit one edge after EOI drops. A wrong merge or polarity gate shows at once, in the same cycle as the stimulus.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int PP_DW     = 8;
    localparam int PP_ADDR_W = 5;
    localparam int PP_LINE_W = $clog2(PP_DW);

    typedef enum logic [1:0] {
        PP_IDLE    = 2'd0,
        PP_STANDBY = 2'd1,
        PP_ACTIVE  = 2'd2
    } pp_state_e;

    typedef struct packed {
        logic                 load;
        logic                 enable;
        logic [PP_LINE_W-1:0] line;
    } pp_cfg_t;

    typedef struct packed {
        pp_state_e            state;
        logic [PP_LINE_W-1:0] line;
    } pp_ctx_t;

    function automatic pp_ctx_t pon_setup(input logic [PP_ADDR_W-1:0] addr);
        pp_ctx_t c;
        if (addr <= PP_ADDR_W'(PP_DW - 1)) begin
            c.state = PP_STANDBY;
            c.line  = addr[PP_LINE_W-1:0] ^ {PP_LINE_W{1'b1}};
        end else begin
            c.state = PP_IDLE;
            c.line  = '0;
        end
        return c;
    endfunction

endpackage

// File: rtl/ppr_cfg_fsm.sv
module ppr_cfg_fsm
    import ppr_pkg::*;
(
    input  logic                 clk,
    input  logic                 pwr_on_clr,
    input  logic [PP_ADDR_W-1:0] dev_addr,
    input  logic                 atn,
    input  logic                 eoi,
    input  pp_cfg_t              cfg,
    output pp_ctx_t              ctx
);
    pp_ctx_t ctx_q, ctx_d;
    logic    poll_seen;

    assign poll_seen = atn && eoi;

    always_comb begin
        ctx_d = ctx_q;
        if (cfg.load) begin
            if (cfg.enable) begin
                ctx_d.line = cfg.line;
                if (ctx_q.state == PP_IDLE) ctx_d.state = PP_STANDBY;
            end else begin
                ctx_d.state = PP_IDLE;
            end
        end else begin
            unique case (ctx_q.state)
                PP_STANDBY: if (poll_seen)  ctx_d.state = PP_ACTIVE;
                PP_ACTIVE:  if (!poll_seen) ctx_d.state = PP_STANDBY;
                default:    ctx_d.state = PP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (pwr_on_clr) ctx_q <= pon_setup(dev_addr);
        else            ctx_q <= ctx_d;
    end

    assign ctx = ctx_q;

    p_enter_active_r3: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (ctx_q.state == PP_STANDBY && poll_seen && !cfg.load) |=> ctx_q.state == PP_ACTIVE);
    p_leave_active_r3: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (ctx_q.state == PP_ACTIVE && !poll_seen && !cfg.load) |=> ctx_q.state == PP_STANDBY);
    p_disable_idle_r8: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (cfg.load && !cfg.enable) |=> ctx_q.state == PP_IDLE);
    p_line_hold_r8: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (!cfg.load) |=> $stable(ctx_q.line));
    p_idle_stays_r2: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (ctx_q.state == PP_IDLE && !cfg.load) |=> ctx_q.state == PP_IDLE);
endmodule

// File: rtl/ppr_encoder.sv
module ppr_encoder
    import ppr_pkg::*;
#(
    parameter int DW     = PP_DW,
    localparam int LW    = $clog2(DW)
) (
    input  logic          clk,
    input  logic          pwr_on_clr,
    input  pp_ctx_t       ctx,
    input  logic          ist_local,
    input  logic          sense_pol,
    output logic [DW-1:0] mask
);
    logic fire;
    assign fire = (ctx.state == PP_ACTIVE) && (ist_local == sense_pol);

    for (genvar i = 0; i < DW; i++) begin : g_line
        assign mask[i] = fire && (LW'(ctx.line) == LW'(i));
    end

    p_onehot_r5: assert property (@(posedge clk) disable iff (pwr_on_clr)
        $onehot0(mask));
    p_quiet_when_not_active_r4: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (ctx.state != PP_ACTIVE) |-> mask == '0);
endmodule

// File: rtl/ppr_merge.sv
module ppr_merge #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          pwr_on_clr,
    input  logic [DW-1:0] src_byte,
    input  logic [DW-1:0] resp_mask,
    input  logic          src_eoi,
    input  logic          ctl_poll,
    output logic [DW-1:0] dio_out,
    output logic          eoi_drive
);
    assign dio_out   = src_byte | resp_mask;
    assign eoi_drive = src_eoi | ctl_poll;

    p_keep_src_r6: assert property (@(posedge clk) disable iff (pwr_on_clr)
        (dio_out & src_byte) == src_byte);
    p_poll_eoi_r7: assert property (@(posedge clk) disable iff (pwr_on_clr)
        ctl_poll |-> eoi_drive);
endmodule

// File: rtl/ppr_responder.sv
module ppr_responder
    import ppr_pkg::*;
(
    input  logic                 clk,
    input  logic                 pwr_on_clr,
    input  logic [PP_ADDR_W-1:0] dev_addr,
    input  logic                 atn,
    input  logic                 eoi,
    input  logic                 ist_local,
    input  logic                 sense_pol,
    input  logic                 cfg_load,
    input  logic                 cfg_enable,
    input  logic [PP_LINE_W-1:0] cfg_line,
    input  logic [PP_DW-1:0]     src_byte,
    input  logic                 src_eoi,
    input  logic                 ctl_poll,
    output logic [PP_DW-1:0]     resp_mask,
    output logic [PP_DW-1:0]     dio_out,
    output logic                 eoi_drive
);
    pp_cfg_t cfg;
    pp_ctx_t ctx;

    assign cfg = '{load: cfg_load, enable: cfg_enable, line: cfg_line};

    ppr_cfg_fsm u_fsm (
        .clk(clk), .pwr_on_clr(pwr_on_clr), .dev_addr(dev_addr),
        .atn(atn), .eoi(eoi), .cfg(cfg), .ctx(ctx)
    );

    ppr_encoder #(.DW(PP_DW)) u_enc (
        .clk(clk), .pwr_on_clr(pwr_on_clr), .ctx(ctx),
        .ist_local(ist_local), .sense_pol(sense_pol), .mask(resp_mask)
    );

    ppr_merge #(.DW(PP_DW)) u_merge (
        .clk(clk), .pwr_on_clr(pwr_on_clr), .src_byte(src_byte),
        .resp_mask(resp_mask), .src_eoi(src_eoi), .ctl_poll(ctl_poll),
        .dio_out(dio_out), .eoi_drive(eoi_drive)
    );

    p_mask_on_entry_r9: assert property (@(posedge clk) disable iff (pwr_on_clr)
        ($past(ctx.state) == PP_STANDBY && ctx.state == PP_ACTIVE && ist_local == sense_pol)
        |-> resp_mask != '0);
endmodule

// File: tb/ppr_responder_test.sv
`timescale 1ns/1ps
module ppr_responder_test;
    logic       clk = 1'b0;
    logic       pwr_on_clr = 1'b1;
    logic [4:0] dev_addr = '0;
    logic       atn = 0, eoi = 0, ist_local = 1, sense_pol = 1;
    logic       cfg_load = 0, cfg_enable = 0;
    logic [2:0] cfg_line = '0;
    logic [7:0] src_byte = '0;
    logic       src_eoi = 0, ctl_poll = 0;
    logic [7:0] resp_mask, dio_out;
    logic       eoi_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    ppr_responder uut (.*);

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic power_on(input logic [4:0] a);
        dev_addr = a; atn = 0; eoi = 0; cfg_load = 0; pwr_on_clr = 1;
        step();
        pwr_on_clr = 0; #1;
    endtask

    task automatic poll_on();
        atn = 1; eoi = 1; step();
    endtask

    task automatic poll_off();
        atn = 0; eoi = 0; step();
    endtask

    task automatic t_pon_low_addr();
        for (int a = 0; a < 8; a++) begin
            power_on(5'(a));
            src_byte = 0; ist_local = 1; sense_pol = 1; #1;
            check("R1 standby no drive", resp_mask, 8'h00);
            poll_on();
            check("R1 pon line addr^7", dio_out, 8'h01 << (a ^ 7));
            poll_off();
        end
    endtask

    task automatic t_pon_high_addr();
        power_on(5'd8);  poll_on(); check("R2 addr 8 idle", dio_out, 8'h00); poll_off();
        power_on(5'd31); poll_on(); check("R2 addr 31 idle", dio_out, 8'h00); poll_off();
    endtask

    task automatic t_sense_and_entry();
        power_on(5'd2);            // line 5
        ist_local = 0; sense_pol = 0;
        poll_on();
        check("R9 response in first active cycle", resp_mask, 8'h20);
        check("R4 sense 0 match", resp_mask, 8'h20);
        ist_local = 1; #1;
        check("R4 sense mismatch", resp_mask, 8'h00);
        sense_pol = 1; #1;
        check("R4 sense 1 match", resp_mask, 8'h20);
        eoi = 0; #1;
        check("R3 still active before edge", resp_mask, 8'h20);
        step();
        check("R3 back to standby on EOI drop", resp_mask, 8'h00);
        eoi = 1; step();
        check("R3 re-enter active", resp_mask, 8'h20);
        atn = 0; step();
        check("R3 back to standby on ATN drop", resp_mask, 8'h00);
        poll_off();
    endtask

    task automatic t_merge();
        power_on(5'd6);            // line 1
        src_byte = 8'hA5; #1;
        check("R6 passthrough no poll", dio_out, 8'hA5);
        poll_on();
        check("R6 merge adds bit", dio_out, 8'hA7);
        check("R5 one-hot line 1", resp_mask, 8'h02);
        src_byte = 8'h02; #1;
        check("R6 merge overlapping bit", dio_out, 8'h02);
        poll_off(); src_byte = 0;
    endtask

    task automatic t_load();
        power_on(5'd12);
        cfg_load = 1; cfg_enable = 1; cfg_line = 3'd7; step(); cfg_load = 0;
        poll_on();
        check("R8 enable from idle line 7", resp_mask, 8'h80);
        cfg_load = 1; cfg_enable = 1; cfg_line = 3'd3; step(); cfg_load = 0; #1;
        check("R8 enable keeps active new line", resp_mask, 8'h08);
        cfg_load = 1; cfg_enable = 0; step(); cfg_load = 0; #1;
        check("R8 disable during poll goes idle", resp_mask, 8'h00);
        poll_off(); poll_on();
        check("R8 idle ignores poll after disable", dio_out, 8'h00);
        poll_off();
        cfg_load = 1; cfg_enable = 1; cfg_line = 3'd0; atn = 1; eoi = 1; step();
        cfg_load = 0; #1;
        check("R8 load wins over poll, standby", resp_mask, 8'h00);
        step();
        check("R5 one-hot line 0", resp_mask, 8'h01);
        poll_off();
    endtask

    task automatic t_eoi();
        src_eoi = 0; ctl_poll = 0; #1;
        check("R7 eoi idle", {7'd0, eoi_drive}, 8'h00);
        ctl_poll = 1; #1;
        check("R7 eoi with controller poll", {7'd0, eoi_drive}, 8'h01);
        ctl_poll = 0; src_eoi = 1; #1;
        check("R7 eoi from source", {7'd0, eoi_drive}, 8'h01);
        src_eoi = 0;
    endtask

    initial begin
        power_on(5'd3);
        check("R1 reset state mask", resp_mask, 8'h00);
        t_pon_low_addr();
        t_pon_high_addr();
        t_sense_and_entry();
        t_merge();
        t_load();
        t_eoi();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule